// File: doc/BRIEF.md
# Dual-Path XGMII Pattern Checker

This block watches two 32-bit XGMII column streams, one on the transmit side and one on the receive side, and checks the payload of every packet against a programmed pattern. Each column has four byte lanes, lane 0 in bits 7:0 up to lane 3 in bits 31:24, and one control bit per lane, bit i for lane i. A packet opens on a start column and closes on the first column that carries a terminate character. Every payload column in between is checked lane by lane.

Three patterns are available. The two fixed patterns compare each lane with a per-lane expected byte and control bit. The incrementing pattern seeds itself from the first payload byte and then expects a byte sequence that rises by one. Each path has its own enable and its own saturating error counter. A shared packet counter and a shared sticky mismatch flag summarise both paths. A clear input drops the flag.

Top module: `xgmii_pattern_checker`

## Requirements
- R1: After reset, `pkt_count`, `tx_err_count` and `rx_err_count` read 0 and `mismatch` reads 0.
- R2: On an idle path, a packet opens on a column whose lane 0 has its control bit set and holds 0xFB. The packet closes on the first later column in which any lane has its control bit set and holds 0xFD, wherever that lane sits. Neither the opening nor the closing column is compared. Each closed packet on an enabled path adds one to `pkt_count`, and two paths closing in the same cycle add two.
- R3: With `pkt_type` 2'b00 (fixed data) or 2'b10 (fixed control), each payload column is compared lane by lane. The byte of lane i must equal `exp_data[8i+7:8i]`, and its control bit must equal `exp_ctrl[i]`. A difference in any lane makes the column a mismatch.
- R4: With `pkt_type` 2'b01 (incrementing), the lane 0 byte of the first payload column seeds the sequence. Lanes 0 to 3 of each column, and then the next column, must rise by one modulo 256. All control bits must be 0. After a mismatch the sequence continues from the expected values, not the received ones.
- R5: With `pkt_type` 2'b11 (reserved), payload columns are never flagged, but packets are still delimited and counted.
- R6: Each mismatched column adds exactly one to that path's 16-bit error counter, however many lanes differ. The counter stops at 65535.
- R7: Any mismatched column on either path sets `mismatch`, which stays set until `clear` is high at a clock edge. A mismatch in the same cycle as `clear` leaves the flag set.
- R8: While a path's enable is low, that path compares nothing, counts no packet and holds its error counter. A packet open when the enable drops is abandoned, so payload and terminate columns arriving later without a new start column have no effect.
- R9: The transmit and receive paths are independent. Errors on one path never change the other path's counter.
- R10: `active` is high whenever `tx_en` or `rx_en` is high.
- R11: Columns outside a packet never change any count or the flag. This includes columns that hold 0xFB on a lane other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Enable for the transmit-path checker |
| rx_en | input | 1 | Enable for the receive-path checker |
| clear | input | 1 | Drops the sticky mismatch flag |
| exp_data | input | 32 | Expected byte for each lane, lane i in bits 8i+7:8i |
| exp_ctrl | input | 4 | Expected control bit for each lane |
| pkt_type | input | 2 | Pattern: 00 fixed data, 01 incrementing, 10 fixed control, 11 reserved |
| tx_data | input | 32 | Transmit column data |
| tx_ctrl | input | 4 | Transmit column control bits |
| rx_data | input | 32 | Receive column data |
| rx_ctrl | input | 4 | Receive column control bits |
| pkt_count | output | 16 | Packets closed on enabled paths (wraps) |
| tx_err_count | output | 16 | Mismatched transmit columns, saturating |
| rx_err_count | output | 16 | Mismatched receive columns, saturating |
| mismatch | output | 1 | Sticky flag for any mismatched column |
| active | output | 1 | High while either path is enabled |

## Verification
Fixed-pattern packets are sent clean, with one wrong byte, with one wrong control bit and with several wrong lanes in one column. Together these show that lanes are compared separately and that a column counts only once. Incrementing packets use a seed that wraps past 0xFF, then a corrupted lane followed by a correct column, then a stray control bit. These show the modulo arithmetic and that the sequence recovers after an error. Other runs cover the reserved type with garbage payload, idle noise with a misplaced start byte, a terminate character on a high lane with bad bytes below it, a path disabled mid-packet and both paths closing together. These separate delimiting, enable gating and per-path independence. A single packet of more than 65535 bad columns drives the transmit counter into saturation.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
    localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;

    typedef enum logic [1:0] {
        PM_FIXED_DATA = 2'b00,
        PM_INCR       = 2'b01,
        PM_FIXED_CTRL = 2'b10,
        PM_RSVD       = 2'b11
    } pkt_mode_e;

    typedef enum logic {
        PS_IDLE    = 1'b0,
        PS_PAYLOAD = 1'b1
    } path_state_e;

endpackage

// File: rtl/xpc_char_detect.sv
module xpc_char_detect
    import xpc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*BYTE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    output logic                    is_start,
    output logic                    has_term
);

    logic [LANES-1:0] term_lane;

    // One terminate detector per lane; any lane closes the packet.
    for (genvar g = 0; g < LANES; g++) begin : g_term
        assign term_lane[g] = col_ctrl[g] && (col_data[g*BYTE_W +: BYTE_W] == CH_TERM);
    end

    // Start is only recognised on lane 0.
    assign is_start = col_ctrl[0] && (col_data[BYTE_W-1:0] == CH_START);
    assign has_term = |term_lane;

endmodule

// File: rtl/xpc_col_cmp.sv
module xpc_col_cmp
    import xpc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*BYTE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    input  pkt_mode_e               mode,
    input  logic [LANES*BYTE_W-1:0] exp_data,
    input  logic [LANES-1:0]        exp_ctrl,
    input  logic                    seed_valid,
    input  logic [BYTE_W-1:0]       seed_byte,
    output logic                    mismatch,
    output logic [BYTE_W-1:0]       next_byte
);

    logic                  incr;
    logic [BYTE_W-1:0]     base;
    logic [LANES-1:0]      lane_bad;

    assign incr = (mode == PM_INCR);
    // First payload column of an incrementing packet seeds from lane 0.
    assign base = seed_valid ? seed_byte : col_data[BYTE_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] want_data;
        logic              want_ctrl;
        assign want_data   = incr ? base + BYTE_W'(g) : exp_data[g*BYTE_W +: BYTE_W];
        assign want_ctrl   = incr ? 1'b0 : exp_ctrl[g];
        assign lane_bad[g] = (col_data[g*BYTE_W +: BYTE_W] != want_data) ||
                             (col_ctrl[g] != want_ctrl);
    end

    assign mismatch  = (mode != PM_RSVD) && (|lane_bad);
    assign next_byte = base + BYTE_W'(LANES);

endmodule

// File: rtl/xpc_path.sv
module xpc_path
    import xpc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [LANES*BYTE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    input  pkt_mode_e               mode,
    input  logic [LANES*BYTE_W-1:0] exp_data,
    input  logic [LANES-1:0]        exp_ctrl,
    output logic                    pkt_done,
    output logic                    col_bad,
    output logic [CNT_W-1:0]        err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        path_state_e       st;
        logic              seeded;
        logic [BYTE_W-1:0] next_byte;
        logic [CNT_W-1:0]  err_cnt;
    } path_t;

    path_t s_d, s_q;

    logic              is_start, has_term;
    logic              cmp_bad;
    logic [BYTE_W-1:0] cmp_next;

    xpc_char_detect #(.LANES(LANES)) u_detect (
        .col_data (col_data),
        .col_ctrl (col_ctrl),
        .is_start (is_start),
        .has_term (has_term)
    );

    xpc_col_cmp #(.LANES(LANES)) u_cmp (
        .col_data   (col_data),
        .col_ctrl   (col_ctrl),
        .mode       (mode),
        .exp_data   (exp_data),
        .exp_ctrl   (exp_ctrl),
        .seed_valid (s_q.seeded),
        .seed_byte  (s_q.next_byte),
        .mismatch   (cmp_bad),
        .next_byte  (cmp_next)
    );

    always_comb begin
        s_d      = s_q;
        pkt_done = 1'b0;
        col_bad  = 1'b0;
        if (!en) begin
            // Disabled: abandon any open packet, keep the counter.
            s_d.st = PS_IDLE;
        end else begin
            case (s_q.st)
                PS_IDLE: begin
                    if (is_start) begin
                        s_d.st     = PS_PAYLOAD;
                        s_d.seeded = 1'b0;
                    end
                end
                PS_PAYLOAD: begin
                    if (has_term) begin
                        s_d.st   = PS_IDLE;
                        pkt_done = 1'b1;
                    end else begin
                        col_bad = cmp_bad;
                        if (mode == PM_INCR) begin
                            s_d.seeded    = 1'b1;
                            s_d.next_byte = cmp_next;
                        end
                        if (cmp_bad && (s_q.err_cnt != CNT_MAX)) begin
                            s_d.err_cnt = s_q.err_cnt + 1'b1;
                        end
                    end
                end
                default: s_d.st = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PS_IDLE, seeded: 1'b0, next_byte: '0, err_cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign err_count = s_q.err_cnt;

endmodule

// File: rtl/xgmii_pattern_checker.sv
module xgmii_pattern_checker
    import xpc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_en,
    input  logic                    rx_en,
    input  logic                    clear,
    input  logic [LANES*BYTE_W-1:0] exp_data,
    input  logic [LANES-1:0]        exp_ctrl,
    input  logic [1:0]              pkt_type,
    input  logic [LANES*BYTE_W-1:0] tx_data,
    input  logic [LANES-1:0]        tx_ctrl,
    input  logic [LANES*BYTE_W-1:0] rx_data,
    input  logic [LANES-1:0]        rx_ctrl,
    output logic [CNT_W-1:0]        pkt_count,
    output logic [CNT_W-1:0]        tx_err_count,
    output logic [CNT_W-1:0]        rx_err_count,
    output logic                    mismatch,
    output logic                    active
);

    localparam int DW     = LANES*BYTE_W;
    localparam int NPATHS = 2;

    typedef struct packed {
        logic [CNT_W-1:0] pkt_cnt;
        logic             sticky;
    } top_t;

    top_t t_d, t_q;

    pkt_mode_e         mode;
    logic [NPATHS-1:0] p_en, p_done, p_bad;
    logic [DW-1:0]     p_data [NPATHS];
    logic [LANES-1:0]  p_ctrl [NPATHS];
    logic [CNT_W-1:0]  p_err  [NPATHS];

    assign mode      = pkt_mode_e'(pkt_type);
    assign p_en      = {rx_en, tx_en};
    assign p_data[0] = tx_data;
    assign p_data[1] = rx_data;
    assign p_ctrl[0] = tx_ctrl;
    assign p_ctrl[1] = rx_ctrl;

    for (genvar p = 0; p < NPATHS; p++) begin : g_path
        xpc_path #(.LANES(LANES), .CNT_W(CNT_W)) u_path (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (p_en[p]),
            .col_data  (p_data[p]),
            .col_ctrl  (p_ctrl[p]),
            .mode      (mode),
            .exp_data  (exp_data),
            .exp_ctrl  (exp_ctrl),
            .pkt_done  (p_done[p]),
            .col_bad   (p_bad[p]),
            .err_count (p_err[p])
        );
    end

    always_comb begin
        t_d         = t_q;
        t_d.pkt_cnt = t_q.pkt_cnt + CNT_W'(p_done[0]) + CNT_W'(p_done[1]);
        // A new mismatch outranks a clear in the same cycle.
        t_d.sticky  = (t_q.sticky && !clear) || (|p_bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{pkt_cnt: '0, sticky: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign pkt_count    = t_q.pkt_cnt;
    assign tx_err_count = p_err[0];
    assign rx_err_count = p_err[1];
    assign mismatch     = t_q.sticky;
    assign active       = tx_en || rx_en;

endmodule

// File: rtl/xpc_checker.sv
module xpc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             rx_en,
    input logic             clear,
    input logic [CNT_W-1:0] pkt_count,
    input logic [CNT_W-1:0] tx_err_count,
    input logic [CNT_W-1:0] rx_err_count,
    input logic             mismatch
);

    // R6
    tx_err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tx_err_count == $past(tx_err_count)) ||
                 (tx_err_count == $past(tx_err_count) + 1'b1));

    // R6
    rx_err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rx_err_count == $past(rx_err_count)) ||
                 (rx_err_count == $past(rx_err_count) + 1'b1));

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> $stable(tx_err_count));

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(rx_err_count));

    // R8
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |=> $stable(pkt_count));

    // R2
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (CNT_W'(pkt_count - $past(pkt_count)) <= CNT_W'(2)));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clear) |=> mismatch);

    // R7
    flag_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_err_count != $past(tx_err_count)) ||
         (rx_err_count != $past(rx_err_count))) |-> mismatch);

endmodule

bind xgmii_pattern_checker xpc_checker #(.CNT_W(CNT_W)) u_xpc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .clear        (clear),
    .pkt_count    (pkt_count),
    .tx_err_count (tx_err_count),
    .rx_err_count (rx_err_count),
    .mismatch     (mismatch)
);

// File: tb/xgmii_pattern_checker_tb_top.sv
module xgmii_pattern_checker_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] IDLE_D  = 32'h07070707;
    localparam logic [3:0]  IDLE_C  = 4'hF;
    localparam logic [31:0] START_D = 32'h555555FB;
    localparam logic [3:0]  START_C = 4'b0001;
    localparam logic [31:0] TERM_D  = 32'h070707FD;
    localparam logic [3:0]  TERM_C  = 4'hF;
    localparam logic [31:0] PAT_D   = 32'h44332211;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, tx_en, rx_en, clear;
    logic [31:0] exp_data, tx_data, rx_data;
    logic [3:0]  exp_ctrl, tx_ctrl, rx_ctrl;
    logic [1:0]  pkt_type;
    logic [15:0] pkt_count, tx_err_count, rx_err_count;
    logic        mismatch, active;

    xgmii_pattern_checker dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .clear(clear),
        .exp_data(exp_data), .exp_ctrl(exp_ctrl), .pkt_type(pkt_type),
        .tx_data(tx_data), .tx_ctrl(tx_ctrl), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .pkt_count(pkt_count), .tx_err_count(tx_err_count), .rx_err_count(rx_err_count),
        .mismatch(mismatch), .active(active)
    );

    typedef struct {
        string       tag;
        logic [15:0] tx, rx, pkt;
        logic        flag, act;
    } exp_t;

    exp_t sbq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   e_tx = 0, e_rx = 0, e_pkt = 0;
    bit   e_flag = 1'b0;

    // Control values applied together with the next column.
    logic       nxt_tx_en = 1'b0, nxt_rx_en = 1'b0, nxt_clear = 1'b0;
    logic [1:0] nxt_type = 2'b00;

    function automatic void chk(string tag, string what, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endfunction

    task automatic col(input logic [31:0] td, input logic [3:0] tc,
                       input logic [31:0] rd, input logic [3:0] rc);
        @(negedge clk);
        tx_en = nxt_tx_en; rx_en = nxt_rx_en; clear = nxt_clear; pkt_type = nxt_type;
        tx_data = td; tx_ctrl = tc; rx_data = rd; rx_ctrl = rc;
        nxt_clear = 1'b0;
    endtask

    task automatic txc(input logic [31:0] d, input logic [3:0] c);
        col(d, c, IDLE_D, IDLE_C);
    endtask

    task automatic rxc(input logic [31:0] d, input logic [3:0] c);
        col(IDLE_D, IDLE_C, d, c);
    endtask

    // Driver side of the scoreboard: snapshot of expected port values.
    task automatic push(input string tag);
        exp_t it;
        it.tag  = tag;
        it.tx   = 16'(e_tx);
        it.rx   = 16'(e_rx);
        it.pkt  = 16'(e_pkt);
        it.flag = e_flag;
        it.act  = tx_en | rx_en;
        sbq.push_back(it);
    endtask

    // Monitor: compare after the edge that registers the last column.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                chk(it.tag, "tx_err_count", int'(tx_err_count), int'(it.tx));
                chk(it.tag, "rx_err_count", int'(rx_err_count), int'(it.rx));
                chk(it.tag, "pkt_count",    int'(pkt_count),    int'(it.pkt));
                chk(it.tag, "mismatch",     int'(mismatch),     int'(it.flag));
                chk({it.tag, " R10"}, "active", int'(active),   int'(it.act));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0; clear = 1'b0; pkt_type = 2'b00;
        exp_data = PAT_D; exp_ctrl = 4'b0000;
        tx_data = IDLE_D; tx_ctrl = IDLE_C; rx_data = IDLE_D; rx_ctrl = IDLE_C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        txc(IDLE_D, IDLE_C);
        push("R1 reset state");

        // R2 R3: clean fixed-data packet on transmit
        nxt_tx_en = 1'b1;
        txc(START_D, START_C);
        for (int i = 0; i < 3; i++) txc(PAT_D, 4'b0000);
        txc(TERM_D, TERM_C);
        e_pkt++;
        push("R2 R3 clean fixed packet");

        // R3 R6: byte error, control error, multi-lane error in one column
        txc(START_D, START_C);
        txc(PAT_D, 4'b0000);
        txc(32'h44332210, 4'b0000);
        txc(PAT_D, 4'b1000);
        txc(32'hAAAAAA11, 4'b0000);
        txc(TERM_D, TERM_C);
        e_tx += 3; e_pkt++; e_flag = 1'b1;
        push("R3 R6 lane mismatches");

        // R7: clear drops the flag, counters hold
        nxt_clear = 1'b1;
        txc(IDLE_D, IDLE_C);
        e_flag = 1'b0;
        push("R7 clear flag");

        // R2: terminate on lane 2, bytes below it not compared
        txc(START_D, START_C);
        txc(PAT_D, 4'b0000);
        txc(32'h07FD9999, 4'b1100);
        e_pkt++;
        push("R2 terminate on lane 2");

        // R3: fixed control pattern
        exp_data = 32'h07070707; exp_ctrl = 4'hF; nxt_type = 2'b10;
        txc(START_D, START_C);
        txc(32'h07070707, 4'hF);
        txc(TERM_D, TERM_C);
        e_pkt++;
        push("R3 fixed control clean");
        txc(START_D, START_C);
        txc(32'h07070707, 4'h7);
        txc(TERM_D, TERM_C);
        e_pkt++; e_tx++; e_flag = 1'b1;
        push("R3 fixed control bad ctrl bit");
        nxt_clear = 1'b1;
        txc(IDLE_D, IDLE_C);
        e_flag = 1'b0;
        push("R7 clear again");

        // R4: incrementing, seed wraps past 0xFF
        nxt_type = 2'b01;
        txc(START_D, START_C);
        txc(32'h0100FFFE, 4'b0000);
        txc(32'h05040302, 4'b0000);
        txc(TERM_D, TERM_C);
        e_pkt++;
        push("R4 incrementing wrap clean");
        txc(START_D, START_C);
        txc(32'h13121110, 4'b0000);
        txc(32'h17AA1514, 4'b0000);
        txc(32'h1B1A1918, 4'b0000);
        txc(TERM_D, TERM_C);
        e_pkt++; e_tx++; e_flag = 1'b1;
        push("R4 incrementing one bad lane");
        txc(START_D, START_C);
        txc(32'h03020100, 4'b0100);
        txc(TERM_D, TERM_C);
        e_pkt++; e_tx++;
        push("R4 incrementing stray control bit");

        // R5: reserved type never flags
        nxt_clear = 1'b1; nxt_type = 2'b11;
        txc(START_D, START_C);
        e_flag = 1'b0;
        txc(32'hDEADBEEF, 4'b0101);
        txc(TERM_D, TERM_C);
        e_pkt++;
        push("R5 reserved type");

        // R11: noise outside a packet
        nxt_type = 2'b00; exp_data = PAT_D; exp_ctrl = 4'b0000;
        txc(32'hDEADBEEF, 4'b0000);
        txc(32'h0707FB07, 4'hF);
        txc(32'h12345678, 4'b0000);
        txc(TERM_D, TERM_C);
        push("R11 idle noise ignored");

        // R8: receive disabled, bad packet ignored
        rxc(START_D, START_C);
        rxc(32'hBAD0BAD0, 4'b0000);
        rxc(TERM_D, TERM_C);
        push("R8 rx disabled");

        // R9: receive enabled, errors land on rx only
        nxt_rx_en = 1'b1;
        rxc(START_D, START_C);
        rxc(32'hBAD0BAD0, 4'b0000);
        rxc(PAT_D, 4'b0000);
        rxc(TERM_D, TERM_C);
        e_rx++; e_pkt++; e_flag = 1'b1;
        push("R9 rx independent");

        // R2: both paths close together
        col(START_D, START_C, START_D, START_C);
        col(PAT_D, 4'b0000, PAT_D, 4'b0000);
        col(TERM_D, TERM_C, TERM_D, TERM_C);
        e_pkt += 2;
        push("R2 dual close");

        // R7: clear with simultaneous mismatch keeps flag set
        nxt_clear = 1'b1;
        txc(IDLE_D, IDLE_C);
        e_flag = 1'b0;
        push("R7 clear before set-wins");
        txc(START_D, START_C);
        nxt_clear = 1'b1;
        txc(32'h00000000, 4'b0000);
        txc(TERM_D, TERM_C);
        e_tx++; e_pkt++; e_flag = 1'b1;
        push("R7 set wins over clear");

        // R8: disable mid-packet abandons it
        txc(START_D, START_C);
        nxt_tx_en = 1'b0;
        txc(32'h00000000, 4'b0000);
        txc(TERM_D, TERM_C);
        push("R8 disabled mid-packet");
        nxt_tx_en = 1'b1;
        txc(32'h00000000, 4'b0000);
        txc(32'h00000000, 4'b0000);
        txc(TERM_D, TERM_C);
        push("R8 no resume without start");

        // R6: saturation of the transmit counter
        txc(START_D, START_C);
        for (int i = 0; i < 65540; i++) txc(32'h00000000, 4'b0000);
        txc(TERM_D, TERM_C);
        e_tx = 65535; e_pkt++;
        push("R6 saturate");
        txc(START_D, START_C);
        txc(32'h00000000, 4'b0000);
        txc(TERM_D, TERM_C);
        e_pkt++;
        push("R6 stays saturated");

        nxt_tx_en = 1'b0; nxt_rx_en = 1'b0;
        txc(IDLE_D, IDLE_C);
        push("R10 both disabled");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule